// File: doc/BRIEF.md
# Agree branch direction predictor

This block predicts whether a conditional branch at a given fetch address will be taken. It differs from a plain two-bit counter predictor in what its shared counters mean. Each counter does not hold a direction. It holds a confidence that the branch will follow a one-bit bias that was recorded for it. The bias is captured from the first resolved outcome that lands on an empty bias entry, and it does not change after that. Branches that collide in the counter table therefore usually push the shared counter the same way, towards "agree", instead of working against each other.

Fetch presents an address with a valid strobe, and the prediction appears one clock later. The two table indices used for that prediction come out with it. The pipeline carries these indices with the branch and hands them back when the branch resolves, together with the real outcome. Resolution trains the bias and counter entries that the prediction read, and it shifts the outcome into a global history register. The history register feeds both index hashes. No tags are stored, so branches whose hashed indices match share their entries. A synchronous flush input returns every piece of state to its reset value, for use on an address-space change.

Top module: `agree_predictor`

## Requirements
- R1: After reset, with all bias entries marked unknown, all counters at weak-agree (2'b10) and history zero, any fetch is predicted not-taken, and no prediction is valid until a fetch arrives.
- R2: A fetch with fetch_valid high and flush low produces pred_valid high on the next clock. A cycle with no fetch produces pred_valid low on the next clock.
- R3: With pc bits s = fetch_pc[11:2] and history h (8 bits, newest outcome in bit 0), the counter index is s XOR (h shifted left by 2) and the bias index is s XOR h zero-extended to 10 bits.
- R4: The prediction is the bias bit when the counter is 2 or 3, and the inverted bias bit when it is 0 or 1. An unknown bias entry reads as 0 (not-taken).
- R5: A resolution that finds its bias entry unknown writes the outcome as the bias and marks the entry known. Later resolutions leave that bias unchanged until a flush or reset.
- R6: On resolution the counter at res_pidx counts up when the outcome equals the entry's bias (after any write from R5) and counts down otherwise, saturating at 3 and 0.
- R7: A counter in the strong-agree state needs two disagreeing resolutions before the predicted direction flips.
- R8: Each resolution shifts the actual outcome into bit 0 of the history. Fetches alone leave the history unchanged.
- R9: Flush clears all tables and the history, exactly as reset does, in one clock. A resolution in the same cycle is dropped, and a fetch in that cycle yields no valid prediction.
- R10: No address tags are kept. Fetch addresses that differ only above bit 11 receive the same indices and the same prediction.
- R11: A fetch in the same cycle as a resolution to the same entries is predicted from the state held before that resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of all predictor state |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_pc | input | 32 | Fetch address |
| pred_valid | output | 1 | Prediction for last cycle's fetch is present |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_pidx | output | 10 | Counter index used for the prediction |
| pred_bidx | output | 10 | Bias index used for the prediction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_taken | input | 1 | Actual outcome of the resolving branch |
| res_pidx | input | 10 | Counter index carried from prediction |
| res_bidx | input | 10 | Bias index carried from prediction |

## Verification
A wrong history register shows up as index values on the very next prediction. A fetch at address zero returns the history itself on pred_bidx, and a shifted copy on pred_pidx. A wrong bias bit or counter step can stay hidden: the predicted direction changes only when the counter crosses its midpoint. Such a fault therefore appears only after a chosen sequence of one or two disagreeing resolutions, followed by a refetch under a known history. The bench sets up that history by resolving not-taken outcomes into spare entries, which brings the history back to zero. A random trace run against an independent model covers the rest of the state.

// File: rtl/agree_bp_pkg.sv
`timescale 1ns/1ps
package agree_bp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_DIS = 2'b00,
        CTR_WEAK_DIS   = 2'b01,
        CTR_WEAK_AGR   = 2'b10,
        CTR_STRONG_AGR = 2'b11
    } agr_ctr_e;

    localparam agr_ctr_e CTR_RESET = CTR_WEAK_AGR;

    typedef struct packed {
        logic       valid;
        logic       taken;
    } pred_out_t;

    typedef struct packed {
        logic       valid;
        logic       taken;
    } res_evt_t;

    // saturating step toward agree (up) or disagree (down)
    function automatic agr_ctr_e ctr_step(agr_ctr_e c, logic agree);
        logic [1:0] v;
        v = c;
        if (agree) begin
            if (v != 2'b11) v = v + 2'd1;
        end else begin
            if (v != 2'b00) v = v - 2'd1;
        end
        return agr_ctr_e'(v);
    endfunction

    // direction from bias and agreement confidence
    function automatic logic agree_dir(agr_ctr_e c, logic bias);
        logic agr;
        agr = (c == CTR_WEAK_AGR) || (c == CTR_STRONG_AGR);
        return agr ? bias : ~bias;
    endfunction

endpackage

// File: rtl/agree_bp_hash.sv
`timescale 1ns/1ps
module agree_bp_hash #(
    parameter int ADDR_W = 32,
    parameter int HIST_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  pidx,
    output logic [IDX_W-1:0]  bidx
);
    localparam int SHIFT = IDX_W - HIST_W;

    logic [IDX_W-1:0] pc_bits;
    logic [IDX_W-1:0] hist_ext;

    always_comb begin
        pc_bits  = pc[IDX_W+1:2];
        hist_ext = IDX_W'(hist);
        // counter table: history pushed toward the top bits
        pidx     = pc_bits ^ (hist_ext << SHIFT);
        // bias table: history folded into the low bits
        bidx     = pc_bits ^ hist_ext;
    end
endmodule

// File: rtl/agree_bp_pht.sv
`timescale 1ns/1ps
module agree_bp_pht
    import agree_bp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_idx,
    output agr_ctr_e         rd_ctr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_agree
);
    localparam int DEPTH = 1 << IDX_W;

    agr_ctr_e ctr_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RESET;
        end else if (upd_en) begin
            ctr_q[upd_idx] <= ctr_step(ctr_q[upd_idx], upd_agree);
        end
    end

    assign rd_ctr = ctr_q[rd_idx];

    AST_CTR_CEIL: assert property (@(posedge clk) disable iff (rst)
        upd_en && !flush && upd_agree && ctr_q[upd_idx] == CTR_STRONG_AGR
        |=> ctr_q[$past(upd_idx)] == CTR_STRONG_AGR); // R6

    AST_CTR_FLOOR: assert property (@(posedge clk) disable iff (rst)
        upd_en && !flush && !upd_agree && ctr_q[upd_idx] == CTR_STRONG_DIS
        |=> ctr_q[$past(upd_idx)] == CTR_STRONG_DIS); // R6

    AST_CTR_RISE: assert property (@(posedge clk) disable iff (rst)
        upd_en && !flush && upd_agree && ctr_q[upd_idx] != CTR_STRONG_AGR
        |=> 2'(ctr_q[$past(upd_idx)]) == 2'(2'($past(ctr_q[upd_idx])) + 2'd1)); // R6

    AST_CTR_DROP: assert property (@(posedge clk) disable iff (rst)
        upd_en && !flush && !upd_agree && ctr_q[upd_idx] != CTR_STRONG_DIS
        |=> 2'(ctr_q[$past(upd_idx)]) == 2'(2'($past(ctr_q[upd_idx])) - 2'd1)); // R6

    AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        flush |=> ctr_q[$past(rd_idx)] == CTR_RESET); // R9
endmodule

// File: rtl/agree_bp_bias.sv
`timescale 1ns/1ps
module agree_bp_bias #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bias,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken,
    output logic             upd_bias
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] bias_q;
    logic [DEPTH-1:0] known_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            bias_q  <= '0;
            known_q <= '0;
        end else if (upd_en && !known_q[upd_idx]) begin
            bias_q[upd_idx]  <= upd_taken;
            known_q[upd_idx] <= 1'b1;
        end
    end

    // unknown entries read as not-taken
    assign rd_bias  = known_q[rd_idx] & bias_q[rd_idx];
    // bias in force once this resolution has been applied
    assign upd_bias = known_q[upd_idx] ? bias_q[upd_idx] : upd_taken;

    AST_BIAS_FIXED: assert property (@(posedge clk) disable iff (rst)
        upd_en && !flush && known_q[upd_idx]
        |=> bias_q[$past(upd_idx)] == $past(bias_q[upd_idx])); // R5

    AST_BIAS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        upd_en && !flush && !known_q[upd_idx]
        |=> known_q[$past(upd_idx)] && bias_q[$past(upd_idx)] == $past(upd_taken)); // R5

    AST_BIAS_WIPE: assert property (@(posedge clk) disable iff (rst)
        flush |=> known_q == '0); // R9
endmodule

// File: rtl/agree_predictor.sv
`timescale 1ns/1ps
module agree_predictor
    import agree_bp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HIST_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic [IDX_W-1:0]  pred_pidx,
    output logic [IDX_W-1:0]  pred_bidx,
    input  logic              res_valid,
    input  logic              res_taken,
    input  logic [IDX_W-1:0]  res_pidx,
    input  logic [IDX_W-1:0]  res_bidx
);
    logic [HIST_W-1:0] hist_q;
    logic [IDX_W-1:0]  f_pidx;
    logic [IDX_W-1:0]  f_bidx;
    agr_ctr_e          f_ctr;
    logic              f_bias;
    logic              u_bias;
    res_evt_t          evt;
    pred_out_t         pred_d;
    pred_out_t         pred_q;
    logic [IDX_W-1:0]  pidx_q;
    logic [IDX_W-1:0]  bidx_q;

    assign evt.valid = res_valid && !flush;
    assign evt.taken = res_taken;

    agree_bp_hash #(
        .ADDR_W (ADDR_W),
        .HIST_W (HIST_W),
        .IDX_W  (IDX_W)
    ) u_hash (
        .pc   (fetch_pc),
        .hist (hist_q),
        .pidx (f_pidx),
        .bidx (f_bidx)
    );

    agree_bp_pht #(.IDX_W(IDX_W)) u_pht (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .rd_idx    (f_pidx),
        .rd_ctr    (f_ctr),
        .upd_en    (evt.valid),
        .upd_idx   (res_pidx),
        .upd_agree (evt.taken == u_bias)
    );

    agree_bp_bias #(.IDX_W(IDX_W)) u_bias_tbl (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .rd_idx    (f_bidx),
        .rd_bias   (f_bias),
        .upd_en    (evt.valid),
        .upd_idx   (res_bidx),
        .upd_taken (evt.taken),
        .upd_bias  (u_bias)
    );

    always_comb begin
        pred_d.valid = fetch_valid;
        pred_d.taken = agree_dir(f_ctr, f_bias);
    end

    // global history: outcome enters at bit 0
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hist_q <= '0;
        end else if (evt.valid) begin
            hist_q <= {hist_q[HIST_W-2:0], evt.taken};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pred_q <= '0;
            pidx_q <= '0;
            bidx_q <= '0;
        end else begin
            pred_q <= pred_d;
            if (fetch_valid) begin
                pidx_q <= f_pidx;
                bidx_q <= f_bidx;
            end
        end
    end

    assign pred_valid = pred_q.valid;
    assign pred_taken = pred_q.taken;
    assign pred_pidx  = pidx_q;
    assign pred_bidx  = bidx_q;

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        res_valid && !flush
        |=> hist_q[0] == $past(res_taken)
            && hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])); // R8

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !res_valid && !flush |=> $stable(hist_q)); // R8

    AST_HIST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        flush |=> hist_q == '0); // R9

    AST_PRED_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && !flush |=> pred_valid); // R2

    AST_PRED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid || flush |=> !pred_valid); // R2
endmodule

// File: tb/agree_predictor_bench.sv
`timescale 1ns/1ps
module agree_predictor_bench;
    localparam int IW    = 10;
    localparam int HW    = 8;
    localparam int DEPTH = 1 << IW;
    localparam logic [31:0] PC_A   = 32'h0000_0100;
    localparam logic [IW-1:0] SPARE = 10'h3FF;
    localparam int NVEC = 16;
    // {outcome, fetch address}
    localparam logic [32:0] VECS [NVEC] = '{
        {1'b1, 32'h0000_0040}, {1'b0, 32'h0000_0044}, {1'b1, 32'h0000_0040},
        {1'b1, 32'h0000_0a08}, {1'b0, 32'h0000_0a08}, {1'b1, 32'h0000_0040},
        {1'b0, 32'h0000_1230}, {1'b0, 32'h0000_1230}, {1'b1, 32'h0000_0ffc},
        {1'b1, 32'h0000_0044}, {1'b0, 32'h0000_0040}, {1'b1, 32'h0000_0a08},
        {1'b1, 32'h0000_0ffc}, {1'b0, 32'h0000_0ffc}, {1'b1, 32'h0000_1230},
        {1'b0, 32'h0000_0044}
    };

    logic clk = 1'b0;
    logic rst, flush, fetch_valid, res_valid, res_taken;
    logic [31:0] fetch_pc;
    logic pred_valid, pred_taken;
    logic [IW-1:0] pred_pidx, pred_bidx, res_pidx, res_bidx;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int          m_ctr   [DEPTH];
    bit          m_bias  [DEPTH];
    bit          m_known [DEPTH];
    logic [HW-1:0] m_hist;
    logic [IW-1:0] last_p, last_b;
    logic          last_t;

    always #4 clk = ~clk;

    agree_predictor u_agree_predictor (
        .clk(clk), .rst(rst), .flush(flush),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .pred_valid(pred_valid), .pred_taken(pred_taken),
        .pred_pidx(pred_pidx), .pred_bidx(pred_bidx),
        .res_valid(res_valid), .res_taken(res_taken),
        .res_pidx(res_pidx), .res_bidx(res_bidx)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [IW-1:0] f_pidx(logic [31:0] pc, logic [HW-1:0] h);
        return pc[11:2] ^ {h, 2'b00};
    endfunction

    function automatic logic [IW-1:0] f_bidx(logic [31:0] pc, logic [HW-1:0] h);
        return pc[11:2] ^ {2'b00, h};
    endfunction

    function automatic logic m_pred(logic [IW-1:0] p, logic [IW-1:0] b);
        logic bias;
        bias = m_known[b] ? m_bias[b] : 1'b0;
        return (m_ctr[p] >= 2) ? bias : !bias;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_ctr[i] = 2; m_bias[i] = 0; m_known[i] = 0;
        end
        m_hist = '0;
    endtask

    task automatic m_update(input logic [IW-1:0] p, input logic [IW-1:0] b, input logic t);
        if (!m_known[b]) begin m_known[b] = 1; m_bias[b] = t; end
        if (t == m_bias[b]) begin
            if (m_ctr[p] < 3) m_ctr[p]++;
        end else begin
            if (m_ctr[p] > 0) m_ctr[p]--;
        end
        m_hist = {m_hist[HW-2:0], t};
    endtask

    // entered at a falling edge, leaves at the next one
    task automatic do_fetch(input logic [31:0] pc, input string tag);
        logic [IW-1:0] ep, eb;
        logic et;
        ep = f_pidx(pc, m_hist);
        eb = f_bidx(pc, m_hist);
        et = m_pred(ep, eb);
        fetch_valid = 1; fetch_pc = pc;
        @(negedge clk);
        fetch_valid = 0;
        chk({tag, " valid"}, 32'(pred_valid), 32'd1);
        chk({tag, " taken"}, 32'(pred_taken), 32'(et));
        chk({tag, " pidx"}, 32'(pred_pidx), 32'(ep));
        chk({tag, " bidx"}, 32'(pred_bidx), 32'(eb));
        last_p = pred_pidx; last_b = pred_bidx; last_t = pred_taken;
    endtask

    task automatic do_res(input logic [IW-1:0] p, input logic [IW-1:0] b, input logic t);
        res_valid = 1; res_taken = t; res_pidx = p; res_bidx = b;
        @(negedge clk);
        res_valid = 0;
        m_update(p, b, t);
    endtask

    // eight not-taken resolutions into a spare entry bring history to zero
    task automatic wash();
        for (int i = 0; i < HW; i++) do_res(SPARE, SPARE, 1'b0);
    endtask

    task automatic do_flush();
        flush = 1;
        @(negedge clk);
        flush = 0;
        m_reset();
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; flush = 0; fetch_valid = 0; fetch_pc = '0;
        res_valid = 0; res_taken = 0; res_pidx = '0; res_bidx = '0;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: quiet after reset, fresh fetch not-taken
        chk("R1 no prediction after reset", 32'(pred_valid), 32'd0);
        do_fetch(PC_A, "R1 fresh fetch");
        chk("R1 fresh direction", 32'(last_t), 32'd0);
        chk("R3 index with zero history", 32'(last_p), 32'h40);
        // R2: idle cycle drops valid
        @(negedge clk);
        chk("R2 idle clears valid", 32'(pred_valid), 32'd0);

        // vector table walk, R3 R4 R5 R6 against model
        for (int v = 0; v < NVEC; v++) begin
            do_fetch(VECS[v][31:0], "R4 vector");
            do_res(last_p, last_b, VECS[v][32]);
        end

        // R8: history observed via address zero
        do_flush();
        do_res(SPARE, SPARE, 1'b1);
        do_res(SPARE, SPARE, 1'b0);
        do_res(SPARE, SPARE, 1'b1);
        do_fetch(32'h0, "R8 history");
        chk("R8 history bits", 32'(last_b), 32'h5);
        chk("R3 shifted history", 32'(last_p), 32'h14);
        do_fetch(32'h0, "R8 fetch holds");
        chk("R8 fetch leaves history", 32'(last_b), 32'h5);

        // R5 R6 R7: training one entry under zero history
        do_flush();
        do_res(10'h40, 10'h40, 1'b0);       // bias 0, counter strong agree
        do_fetch(PC_A, "R5 after fill");
        chk("R5 fill sets bias", 32'(last_t), 32'd0);
        do_res(10'h40, 10'h40, 1'b1);
        wash();
        do_fetch(PC_A, "R7 one miss");
        chk("R7 one disagreement keeps direction", 32'(last_t), 32'd0);
        do_res(10'h40, 10'h40, 1'b1);
        wash();
        do_fetch(PC_A, "R7 two misses");
        chk("R7 two disagreements flip", 32'(last_t), 32'd1);
        do_res(10'h40, 10'h40, 1'b1);
        do_res(10'h40, 10'h40, 1'b1);
        do_res(10'h40, 10'h40, 1'b0);
        wash();
        do_fetch(PC_A, "R6 floor");
        chk("R6 floor saturates and bias stays", 32'(last_t), 32'd1);
        // R10: alias above index bits
        do_fetch(PC_A | 32'h0000_1000, "R10 alias");
        chk("R10 alias shares entry", 32'(last_t), 32'd1);
        chk("R10 alias index", 32'(last_p), 32'h40);
        // R6 ceiling: drive agreement well past 3, one miss stays agree
        for (int i = 0; i < 6; i++) do_res(10'h40, 10'h40, 1'b0);
        do_res(10'h40, 10'h40, 1'b1);
        wash();
        do_fetch(PC_A, "R6 ceiling");
        chk("R6 ceiling saturates", 32'(last_t), 32'd0);

        // R9: flush with a resolution in the same cycle
        flush = 1; res_valid = 1; res_taken = 1; res_pidx = 10'h40; res_bidx = 10'h40;
        fetch_valid = 1; fetch_pc = PC_A;
        @(negedge clk);
        flush = 0; res_valid = 0; fetch_valid = 0;
        m_reset();
        chk("R9 fetch during flush gives nothing", 32'(pred_valid), 32'd0);
        do_fetch(PC_A, "R9 after flush");
        chk("R9 resolution dropped, history zero", 32'(last_b), 32'h40);
        chk("R9 tables cleared", 32'(last_t), 32'd0);

        // R11: same-cycle fetch and resolution read old state
        do_flush();
        fetch_valid = 1; fetch_pc = PC_A;
        res_valid = 1; res_taken = 1; res_pidx = 10'h40; res_bidx = 10'h40;
        @(negedge clk);
        fetch_valid = 0; res_valid = 0;
        m_update(10'h40, 10'h40, 1'b1);
        chk("R11 prediction uses old state", 32'(pred_taken), 32'd0);
        wash();
        do_fetch(PC_A, "R11 update landed");
        chk("R11 update visible later", 32'(last_t), 32'd1);

        // random trace against the model
        do_flush();
        for (int n = 0; n < 400; n++) begin
            int k;
            logic t;
            k = $urandom_range(0, 31);
            t = ($urandom_range(0, 9) < 8) ? k[0] : !k[0];
            do_fetch(32'h0000_2000 + 32'(k * 36), "R4 random");
            do_res(last_p, last_b, t);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule